// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block is the digital side of an analog voltage comparator. The comparator's raw output arrives as an asynchronous single bit. The block resynchronizes it and looks for rising and falling transitions. Each transition kind sets its own sticky flag. Two per-edge mask bits combine the flags into a single interrupt request.

A control register holds three things: the comparator enable, the two 2-bit hysteresis codes and a 2-bit response-mode code. These codes drive the analog block directly.

The analog front end produces spurious transitions just after it is switched on or reconfigured. To hide them, a blanking window of programmable length opens after such events, and edges seen during the window are discarded. Software reaches all registers through a small synchronous bus. Reads are combinational on the address, and writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `cmp_edge_irq`

## Requirements
- R1: `cmp_raw` passes through two synchronizer flops. A change of `cmp_raw` set up before clock edge k shows in the read-only status bit (CTRL bit 6) after edge k+1, and not after edge k.
- R2: While the comparator is enabled and no blanking is active, a 0-to-1 transition of `cmp_raw` set up before edge k sets the rising flag (FLAGS bit 0). The flag reads 1 after edge k+2.
- R3: Under the same conditions, a 1-to-0 transition sets the falling flag (FLAGS bit 1). A 1-to-0 transition leaves the rising flag untouched, and a 0-to-1 transition leaves the falling flag untouched.
- R4: Both flags are sticky. A write to FLAGS (address 1) clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, so software can never set a flag.
- R5: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R6: `irq` equals (rising flag AND MASK bit 0) OR (falling flag AND MASK bit 1), where MASK is at address 2. A mask bit of 1 enables its flag.
- R7: While the enable bit (CTRL bit 7) is 0, `irq` is 0 and edges do not set flags. Disabling the comparator does not clear the flags.
- R8: A CTRL write that turns the enable bit from 0 to 1 at edge w starts a blanking window of L = BLANK (address 3) cycles. A transition set up d cycles after the write's closing negedge is recorded only if d+2 >= L. With L = 0 there is no blanking.
- R9: A CTRL write that changes the response-mode or either hysteresis field starts the same window. Rewriting the same values does not start it.
- R10: CTRL layout: bits 1:0 are the negative hysteresis code, bits 3:2 the positive hysteresis code, bits 5:4 the response mode and bit 7 the enable. These appear unchanged on `hyst_neg`, `hyst_pos`, `resp_mode` and `cmp_en`, and they read back.
- R11: After reset, CTRL, FLAGS and MASK read 0, BLANK reads 16, and `irq` and `cmp_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Raw asynchronous comparator output |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 FLAGS, 2 MASK, 3 BLANK |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cmp_en | output | 1 | Comparator enable to the analog block |
| hyst_neg | output | 2 | Negative hysteresis code |
| hyst_pos | output | 2 | Positive hysteresis code |
| resp_mode | output | 2 | Response-time mode code |
| irq | output | 1 | Interrupt request |

## Verification
The internal state shows up at the ports quickly, which bounds how long a fault can stay hidden:
- A synchronizer stage too many or too few shifts the status bit and the flags by one cycle from the edge counts in R1 and R2.
- A blanking counter that is off by one moves the boundary of the delay sweep by one step.
- A missing reload shows as a spurious edge recorded right after an enable or a mode change.
- A flag that is lost, or that software can set, shows at the next FLAGS read and, if its mask bit is set, on `irq` in the same cycle.
- Wrong clear priority shows at the FLAGS read that directly follows a colliding write.

// File: rtl/cmp_edge_pkg.sv
`timescale 1ns/1ps
package cmp_edge_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int NUM_EDGES = 2;
    localparam int EDGE_RISE = 0;
    localparam int EDGE_FALL = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_BLANK = 2'd3;

    // control word, MSB first; status is read-only
    typedef struct packed {
        logic       en;
        logic       status;
        logic [1:0] resp;
        logic [1:0] hpos;
        logic [1:0] hneg;
    } ctrl_t;

    function automatic logic mode_differs(ctrl_t a, ctrl_t b);
        return (a.resp != b.resp) || (a.hpos != b.hpos) || (a.hneg != b.hneg);
    endfunction

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cmp_blank.sv
`timescale 1ns/1ps
module cmp_blank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         active
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = len;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/cmp_flag.sv
`timescale 1ns/1ps
module cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        // hardware set outranks software clear
        flag_d = set | (flag_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/cmp_edge_irq.sv
`timescale 1ns/1ps
module cmp_edge_irq
    import cmp_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_W     = 8,
    parameter int BLANK_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmp_en,
    output logic [1:0]        hyst_neg,
    output logic [1:0]        hyst_pos,
    output logic [1:0]        resp_mode,
    output logic              irq
);
    typedef struct packed {
        logic                 en;
        logic [1:0]           resp;
        logic [1:0]           hpos;
        logic [1:0]           hneg;
        logic [NUM_EDGES-1:0] mask;
        logic [BLANK_W-1:0]   blen;
    } cfg_t;

    cfg_t st_d, st_q;

    logic                 level;
    logic                 wr_ctrl, wr_flag, wr_mask, wr_blank;
    logic                 blank_load, blank_act, arm;
    ctrl_t                wr_word, cur_ctrl;
    logic [NUM_EDGES-1:0] edge_vec, flag_vec, set_vec, clr_vec, mask_vec, hit_vec;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_raw),
        .level    (level),
        .rise     (edge_vec[EDGE_RISE]),
        .fall     (edge_vec[EDGE_FALL])
    );

    cmp_blank #(.W(BLANK_W)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (blank_load),
        .len    (st_q.blen),
        .active (blank_act)
    );

    always_comb begin
        wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
        wr_flag  = bus_sel && bus_wr && (bus_addr == ADDR_FLAG);
        wr_mask  = bus_sel && bus_wr && (bus_addr == ADDR_MASK);
        wr_blank = bus_sel && bus_wr && (bus_addr == ADDR_BLANK);
        wr_word  = ctrl_t'(bus_wdata);

        cur_ctrl        = '0;
        cur_ctrl.en     = st_q.en;
        cur_ctrl.status = level;
        cur_ctrl.resp   = st_q.resp;
        cur_ctrl.hpos   = st_q.hpos;
        cur_ctrl.hneg   = st_q.hneg;

        blank_load = wr_ctrl &&
                     ((wr_word.en && !st_q.en) || mode_differs(wr_word, cur_ctrl));
        arm        = st_q.en && !blank_act;

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en   = wr_word.en;
            st_d.resp = wr_word.resp;
            st_d.hpos = wr_word.hpos;
            st_d.hneg = wr_word.hneg;
        end
        if (wr_mask)  st_d.mask = bus_wdata[NUM_EDGES-1:0];
        if (wr_blank) st_d.blen = bus_wdata[BLANK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.blen <= BLANK_W'(BLANK_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_vec = st_q.mask;

    for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
        assign set_vec[g] = arm && edge_vec[g];
        assign clr_vec[g] = wr_flag && !bus_wdata[g];
        assign hit_vec[g] = flag_vec[g] && mask_vec[g];

        cmp_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[g]),
            .clr   (clr_vec[g]),
            .flag  (flag_vec[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = cur_ctrl;
            ADDR_FLAG:  bus_rdata[NUM_EDGES-1:0] = flag_vec;
            ADDR_MASK:  bus_rdata[NUM_EDGES-1:0] = st_q.mask;
            default:    bus_rdata[BLANK_W-1:0]   = st_q.blen;
        endcase
    end

    assign cmp_en    = st_q.en;
    assign hyst_neg  = st_q.hneg;
    assign hyst_pos  = st_q.hpos;
    assign resp_mode = st_q.resp;
    assign irq       = st_q.en && (hit_vec != '0);
endmodule

// File: rtl/cmp_edge_irq_chk.sv
`timescale 1ns/1ps
module cmp_edge_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       cmp_en,
    input logic [1:0] hyst_neg,
    input logic [1:0] hyst_pos,
    input logic [1:0] resp_mode,
    input logic       irq,
    input logic [1:0] flags,
    input logic [1:0] mask,
    input logic [1:0] edges,
    input logic       blank_active
);
    logic wr_ctrl, clr_rise, clr_fall;
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == 2'd0);
    assign clr_rise = bus_sel && bus_wr && (bus_addr == 2'd1) && !bus_wdata[0];
    assign clr_fall = bus_sel && bus_wr && (bus_addr == 2'd1) && !bus_wdata[1];

    assert_irq_quiet_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> !irq);

    assert_no_flag_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !flags[0]) |=> !flags[0]);

    assert_rise_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !clr_rise) |=> flags[0]);

    assert_fall_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr_fall) |=> flags[1]);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edges[0] && cmp_en && !blank_active) |=> flags[0]);

    assert_blank_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_active && !flags[0]) |=> !flags[0]);

    assert_blank_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_active && !flags[1]) |=> !flags[1]);

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & mask) != 2'b00));

    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable({cmp_en, resp_mode, hyst_pos, hyst_neg}));
endmodule

bind cmp_edge_irq cmp_edge_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .cmp_en       (cmp_en),
    .hyst_neg     (hyst_neg),
    .hyst_pos     (hyst_pos),
    .resp_mode    (resp_mode),
    .irq          (irq),
    .flags        (flag_vec),
    .mask         (mask_vec),
    .edges        (edge_vec),
    .blank_active (blank_act)
);

// File: tb/cmp_edge_irq_test.sv
`timescale 1ns/1ps
module cmp_edge_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_en, irq;
    logic [1:0] hyst_neg, hyst_pos, resp_mode;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam int BL = 6;

    always #2.5 clk = ~clk;

    cmp_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_en(cmp_en), .hyst_neg(hyst_neg), .hyst_pos(hyst_pos),
        .resp_mode(resp_mode), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] cw(input logic en, input logic [1:0] rm,
                                      input logic [1:0] hp, input logic [1:0] hn);
        return {en, 1'b0, rm, hp, hn};
    endfunction

    // one blanking trial; returns flags read after the transition
    task automatic trial(input bit fall, input int d, input bit by_mode, output logic [7:0] fl);
        wr(2'd0, cw(1'b0, 2'd0, 2'd0, 2'd0));
        cmp_raw = fall;
        repeat (4) @(negedge clk);
        wr(2'd1, 8'h00);
        if (by_mode) begin
            wr(2'd0, cw(1'b1, 2'd0, 2'd0, 2'd0));
            repeat (BL + 4) @(negedge clk);
            wr(2'd0, cw(1'b1, 2'd0, 2'd2, 2'd0));
        end else begin
            wr(2'd0, cw(1'b1, 2'd0, 2'd0, 2'd0));
        end
        repeat (d) @(negedge clk);
        cmp_raw = ~fall;
        repeat (5) @(negedge clk);
        rd(2'd1, fl);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] fl;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values
        rd(2'd0, v); check("R11 ctrl", v, 8'h00);
        rd(2'd1, v); check("R11 flags", v, 8'h00);
        rd(2'd2, v); check("R11 mask", v, 8'h00);
        rd(2'd3, v); check("R11 blank", v, 8'd16);
        check("R11 irq", irq, 0);
        check("R11 cmp_en", cmp_en, 0);

        // R10 every field combination with the comparator off
        for (int c = 0; c < 64; c++) begin
            wr(2'd0, 8'(c));
            check("R10 hyst_neg", hyst_neg, c & 3);
            check("R10 hyst_pos", hyst_pos, (c >> 2) & 3);
            check("R10 resp_mode", resp_mode, (c >> 4) & 3);
            check("R10 cmp_en", cmp_en, 0);
            rd(2'd0, v); check("R10 readback", v, 32'(c));
        end
        wr(2'd0, 8'h00);

        // R1 synchronizer latency, both directions
        @(negedge clk); bus_addr = 2'd0; cmp_raw = 1'b1;
        @(negedge clk); #1 check("R1 rise not yet", bus_rdata[6], 0);
        @(negedge clk); #1 check("R1 rise seen", bus_rdata[6], 1);
        cmp_raw = 1'b0;
        @(negedge clk); #1 check("R1 fall not yet", bus_rdata[6], 1);
        @(negedge clk); #1 check("R1 fall seen", bus_rdata[6], 0);
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 no flags while off", v, 8'h00);
        check("R7 irq off", irq, 0);

        wr(2'd3, 8'(BL));
        wr(2'd2, 8'h03);

        // R8 / R2 / R3 blanking sweep after enable, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < BL + 3; d++) begin
                logic hit;
                hit = (d + 2 >= BL);
                trial(p[0], d, 1'b0, fl);
                if (p == 0) check("R8 R2 rise after enable", fl, {7'd0, hit});
                else        check("R8 R3 fall after enable", fl, {6'd0, hit, 1'b0});
                check("R6 irq follows flag", irq, hit);
            end
        end

        // R9 blanking sweep after mode change
        for (int d = 0; d < BL + 3; d++) begin
            trial(1'b0, d, 1'b1, fl);
            check("R9 rise after mode change", fl, {7'd0, 1'(d + 2 >= BL)});
        end

        // R9 same-value rewrite opens no window
        wr(2'd0, cw(1'b0, 2'd1, 2'd1, 2'd1));
        cmp_raw = 1'b0;
        wr(2'd0, cw(1'b1, 2'd1, 2'd1, 2'd1));
        repeat (BL + 4) @(negedge clk);
        wr(2'd1, 8'h00);
        wr(2'd0, cw(1'b1, 2'd1, 2'd1, 2'd1));
        cmp_raw = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd1, v); check("R9 rewrite no blank", v, 8'h01);

        // R8 zero-length window
        wr(2'd3, 8'd0);
        trial(1'b0, 0, 1'b0, fl);
        check("R8 zero blank", fl, 8'h01);
        wr(2'd3, 8'(BL));

        // R4 sticky and clear semantics (rise flag is set, raw is 1)
        repeat (20) @(negedge clk);
        rd(2'd1, v); check("R4 still set", v, 8'h01);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R4 write one no effect", v, 8'h01);
        wr(2'd1, 8'h02);
        rd(2'd1, v); check("R4 write zero clears", v, 8'h00);

        // R5 set and clear in the same cycle
        cmp_raw = 1'b0;
        repeat (5) @(negedge clk);
        wr(2'd1, 8'hFE);
        rd(2'd1, v); check("R4 fall kept, rise cleared", v, 8'h02);
        @(negedge clk); cmp_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(2'd1, v); check("R5 set beats clear", v, 8'h01);

        // R6 exhaustive flag x mask
        cmp_raw = 1'b0;
        repeat (5) @(negedge clk);
        for (int c = 0; c < 16; c++) begin
            logic rf, ff, rie, fie;
            rf = c[0]; ff = c[1]; rie = c[2]; fie = c[3];
            cmp_raw = 1'b1; repeat (4) @(negedge clk);
            cmp_raw = 1'b0; repeat (4) @(negedge clk);
            wr(2'd1, {6'd0, ff, rf});
            wr(2'd2, {6'd0, fie, rie});
            rd(2'd1, v); check("R6 flags set", v, {6'd0, ff, rf});
            check("R6 irq", irq, (rf & rie) | (ff & fie));
        end

        // R7 disable forces irq low, flags kept
        wr(2'd2, 8'h03);
        rd(2'd1, v); check("R6 both flags", v, 8'h03);
        check("R6 irq on", irq, 1);
        wr(2'd0, cw(1'b0, 2'd0, 2'd0, 2'd0));
        check("R7 irq off when disabled", irq, 0);
        rd(2'd1, v); check("R7 flags kept", v, 8'h03);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule